// File: doc/BRIEF.md
# Flash Sector Map and Write-Lock Gate

This block sits in front of the program/erase engine of a 64 Mbit, 16-bit-word flash array that is split into four banks. It takes a word address and works out which bank and which sector it falls in. Sectors are numbered globally from the lowest address upward. The two outer banks carry small 4 Kword boot sectors at the extreme ends of the address range. All other sectors are 32 Kword.

The block also decides whether a program or erase request aimed at that sector may proceed. Four sources can lock a sector: a per-sector persistent lock bit, a per-sector volatile lock bit, an active-low boot-guard pin that locks the outermost boot sectors, and an active-low lock-all pin. The effective lock is the OR of every source that applies.

The decode and the lock decision are combinational. When a request is granted, the bank it targets is captured in a register, so that a bank arbiter can compare later reads against the bank that is busy.

Top module: `flash_sector_gate`

## Requirements
- R1: `bank_o` is 0 for word addresses below 0x080000, 1 for addresses below 0x200000, 2 for addresses below 0x380000, and 3 for all higher addresses.
- R2: `sector_o` numbers the sectors from 0 at address 0. Sectors 0-7 are 4 Kword, sectors 8-22 are the 32 Kword part of bank 0, sectors 23-70 are bank 1, sectors 71-118 are bank 2, sectors 119-133 are the 32 Kword part of bank 3, and sectors 134-141 are 4 Kword.
- R3: `boot_o` is high exactly when the addressed sector is one of the 4 Kword sectors (0-7 or 134-141).
- R4: While `guard_n_i` is low, sectors 0-3 and 138-141 are locked whatever their lock bits hold. Sectors 4-7 and 134-137 are not affected by this pin.
- R5: While `lock_all_n_i` is low, every sector is locked.
- R6: Bit i of `persist_lock_i`, and bit i of `volatile_lock_i`, each lock global sector i when set. A clear bit locks nothing. With both pins high, `locked_o` equals the OR of the two bits for the addressed sector.
- R7: `allow_o` is high in the same cycle exactly when `req_i` is high and `locked_o` is low. `locked_o` does not depend on `req_i`.
- R8: After reset, `grant_o` and `grant_bank_o` are 0. One clock after a cycle with `allow_o` high, `grant_o` is 1 and `grant_bank_o` holds the bank of that request. After any other cycle, `grant_o` is 0 and `grant_bank_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 22 | Word address of the request |
| req_i | input | 1 | Program or erase request valid |
| guard_n_i | input | 1 | Active-low boot-guard pin |
| lock_all_n_i | input | 1 | Active-low lock-all pin |
| persist_lock_i | input | 142 | Persistent lock bit per global sector |
| volatile_lock_i | input | 142 | Volatile lock bit per global sector |
| bank_o | output | 2 | Decoded bank |
| sector_o | output | 8 | Decoded global sector |
| boot_o | output | 1 | Addressed sector is a 4 Kword boot sector |
| locked_o | output | 1 | Addressed sector is locked |
| allow_o | output | 1 | Request may proceed |
| grant_o | output | 1 | Registered grant pulse |
| grant_bank_o | output | 2 | Bank of the last granted request |

## Verification
The hardest case to reach is the seam between the 4 Kword and 32 Kword regions inside the outer banks. Here the boot-guard pin must lock only half of the small sectors, and an off-by-one in either the decode or the guard mask produces no visible effect away from those eight words.

The stimulus walks the first and last word of every one of the 142 sectors. It does this once with the pins inactive and random lock bits, and once more over all sixteen boot sectors with the guard pin low. A behavioural sector table built from sector sizes predicts every output on every clock.

// File: rtl/flash_sector_pkg.sv
package flash_sector_pkg;

    parameter int ADDR_W        = 22;
    parameter int BOOT_W        = 12;
    parameter int MAIN_W        = 15;
    parameter int BOOT_PER_END  = 8;
    parameter int GUARD_PER_END = 4;
    parameter int BANK0_MB      = 8;
    parameter int BANK1_MB      = 24;
    parameter int BANK2_MB      = 24;

    localparam int UNIT_W      = ADDR_W - BOOT_W;
    localparam int TOTAL_UNITS = 1 << UNIT_W;
    localparam int RATIO_W     = MAIN_W - BOOT_W;
    localparam int UNITS_PER_MB = (1 << 16) >> BOOT_W;
    localparam int B0_END      = BANK0_MB * UNITS_PER_MB;
    localparam int B1_END      = B0_END + BANK1_MB * UNITS_PER_MB;
    localparam int B2_END      = B1_END + BANK2_MB * UNITS_PER_MB;
    localparam int MAIN_SECTS  = (TOTAL_UNITS - 2 * BOOT_PER_END) >> RATIO_W;
    localparam int SECT_CNT    = 2 * BOOT_PER_END + MAIN_SECTS;
    localparam int SECT_W      = $clog2(SECT_CNT);
    localparam int BANK_W      = 2;
    localparam int TOP_BOOT_U  = TOTAL_UNITS - BOOT_PER_END;
    localparam int TOP_FIRST_S = BOOT_PER_END + MAIN_SECTS;

    typedef logic [UNIT_W-1:0] unit_t;
    typedef logic [SECT_W-1:0] sect_t;
    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        bank_t bank;
        sect_t sector;
        logic  boot;
    } sect_loc_t;

    function automatic bank_t unit_bank(unit_t u);
        if (u < unit_t'(B0_END))      return bank_t'(0);
        else if (u < unit_t'(B1_END)) return bank_t'(1);
        else if (u < unit_t'(B2_END)) return bank_t'(2);
        else                          return bank_t'(3);
    endfunction

    function automatic sect_t unit_sector(unit_t u);
        unit_t off;
        if (u < unit_t'(BOOT_PER_END)) begin
            return sect_t'(u);
        end else if (u >= unit_t'(TOP_BOOT_U)) begin
            off = u - unit_t'(TOP_BOOT_U);
            return sect_t'(off) + sect_t'(TOP_FIRST_S);
        end else begin
            off = (u - unit_t'(BOOT_PER_END)) >> RATIO_W;
            return sect_t'(off) + sect_t'(BOOT_PER_END);
        end
    endfunction

endpackage

// File: rtl/sector_decode.sv
module sector_decode
    import flash_sector_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output sect_loc_t         loc_o
);
    unit_t unit;

    assign unit = addr_i[ADDR_W-1:BOOT_W];

    always_comb begin
        loc_o.bank   = unit_bank(unit);
        loc_o.sector = unit_sector(unit);
        loc_o.boot   = (unit < unit_t'(BOOT_PER_END)) || (unit >= unit_t'(TOP_BOOT_U));
    end

    logic unused_low;
    assign unused_low = ^addr_i[BOOT_W-1:0];
endmodule

// File: rtl/lock_gate.sv
module lock_gate
    import flash_sector_pkg::*;
(
    input  sect_t               sector_i,
    input  logic                guard_n_i,
    input  logic                lock_all_n_i,
    input  logic [SECT_CNT-1:0] persist_i,
    input  logic [SECT_CNT-1:0] volatile_i,
    output logic                locked_o
);
    logic [SECT_CNT-1:0] eff_lock;
    logic                guard_on;
    logic                all_on;

    assign guard_on = ~guard_n_i;
    assign all_on   = ~lock_all_n_i;

    for (genvar i = 0; i < SECT_CNT; i++) begin : g_sect
        if ((i < GUARD_PER_END) || (i >= SECT_CNT - GUARD_PER_END)) begin : g_guarded
            assign eff_lock[i] = persist_i[i] | volatile_i[i] | all_on | guard_on;
        end else begin : g_plain
            assign eff_lock[i] = persist_i[i] | volatile_i[i] | all_on;
        end
    end

    assign locked_o = eff_lock[sector_i];
endmodule

// File: rtl/grant_reg.sv
module grant_reg
    import flash_sector_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  allow_i,
    input  bank_t bank_i,
    output logic  grant_o,
    output bank_t grant_bank_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            grant_o      <= 1'b0;
            grant_bank_o <= '0;
        end else begin
            grant_o <= allow_i;
            if (allow_i) grant_bank_o <= bank_i;
        end
    end

    AST_GRANT_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
        allow_i |=> (grant_o && grant_bank_o == $past(bank_i))); // R8
    AST_BANK_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        !allow_i |=> (!grant_o && $stable(grant_bank_o))); // R8
endmodule

// File: rtl/flash_sector_gate.sv
module flash_sector_gate
    import flash_sector_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                req_i,
    input  logic                guard_n_i,
    input  logic                lock_all_n_i,
    input  logic [SECT_CNT-1:0] persist_lock_i,
    input  logic [SECT_CNT-1:0] volatile_lock_i,
    output logic [BANK_W-1:0]   bank_o,
    output logic [SECT_W-1:0]   sector_o,
    output logic                boot_o,
    output logic                locked_o,
    output logic                allow_o,
    output logic                grant_o,
    output logic [BANK_W-1:0]   grant_bank_o
);
    sect_loc_t loc;

    sector_decode u_decode (
        .addr_i (addr_i),
        .loc_o  (loc)
    );

    lock_gate u_lock (
        .sector_i     (loc.sector),
        .guard_n_i    (guard_n_i),
        .lock_all_n_i (lock_all_n_i),
        .persist_i    (persist_lock_i),
        .volatile_i   (volatile_lock_i),
        .locked_o     (locked_o)
    );

    assign bank_o   = loc.bank;
    assign sector_o = loc.sector;
    assign boot_o   = loc.boot;
    assign allow_o  = req_i & ~locked_o;

    grant_reg u_grant (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .allow_i      (allow_o),
        .bank_i       (loc.bank),
        .grant_o      (grant_o),
        .grant_bank_o (grant_bank_o)
    );

    AST_LOW_BANK0: assert property (@(posedge clk_i) disable iff (rst_i)
        (sector_o < sect_t'(BOOT_PER_END + (B0_END - BOOT_PER_END) / 8)) |-> (bank_o == 2'd0)); // R2
    AST_BOOT_AT_ENDS: assert property (@(posedge clk_i) disable iff (rst_i)
        boot_o |-> ((sector_o < sect_t'(BOOT_PER_END)) || (sector_o >= sect_t'(TOP_FIRST_S)))); // R3
    AST_BOOT_BANKS: assert property (@(posedge clk_i) disable iff (rst_i)
        boot_o |-> ((bank_o == 2'd0) || (bank_o == 2'd3))); // R3
    AST_GUARD_LOCKS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!guard_n_i && ((sector_o < sect_t'(GUARD_PER_END)) ||
                        (sector_o >= sect_t'(SECT_CNT - GUARD_PER_END)))) |-> locked_o); // R4
    AST_LOCK_ALL: assert property (@(posedge clk_i) disable iff (rst_i)
        !lock_all_n_i |-> !allow_o); // R5
    AST_ALLOW_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        allow_o |-> (req_i && !locked_o)); // R7
endmodule

// File: tb/flash_sector_gate_bench.sv
module flash_sector_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 142;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [21:0] addr = '0;
    logic req = 1'b0, guard_n = 1'b1, lock_all_n = 1'b1;
    logic [NS-1:0] pbits = '0, vbits = '0;
    logic [1:0] bank_o, grant_bank_o;
    logic [7:0] sector_o;
    logic boot_o, locked_o, allow_o, grant_o;

    int checks = 0;
    int errors = 0;
    bit m_grant = 1'b0;
    int m_gbank = 0;

    int unsigned s_start[$];
    int unsigned s_size[$];
    int s_bank[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_sector_gate u_flash_sector_gate (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .req_i(req),
        .guard_n_i(guard_n), .lock_all_n_i(lock_all_n),
        .persist_lock_i(pbits), .volatile_lock_i(vbits),
        .bank_o(bank_o), .sector_o(sector_o), .boot_o(boot_o),
        .locked_o(locked_o), .allow_o(allow_o),
        .grant_o(grant_o), .grant_bank_o(grant_bank_o)
    );

    task automatic add_run(int bank, int count, int unsigned size);
        int unsigned base;
        base = (s_start.size() == 0) ? 0 : s_start[$] + s_size[$];
        for (int k = 0; k < count; k++) begin
            s_start.push_back(base + k * size);
            s_size.push_back(size);
            s_bank.push_back(bank);
        end
    endtask

    function automatic int find_sector(int unsigned a);
        for (int k = 0; k < s_start.size(); k++)
            if (a >= s_start[k] && a < s_start[k] + s_size[k]) return k;
        return -1;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(logic [21:0] a, logic r, logic g, logic l);
        int idx;
        bit eboot, elock, eallow, gsec;
        string ltag;
        @(negedge clk);
        chk(grant_o === m_grant, "R8 grant", grant_o, m_grant);
        chk(grant_bank_o === 2'(m_gbank), "R8 grant_bank", grant_bank_o, m_gbank);
        addr = a; req = r; guard_n = g; lock_all_n = l;
        #1;
        idx   = find_sector(a);
        eboot = (s_size[idx] == 4096);
        gsec  = (idx < 4) || (idx >= NS - 4);
        elock = pbits[idx] | vbits[idx] | !l | (!g && gsec);
        eallow = r && !elock;
        if (!l) ltag = "R5 locked";
        else if (!g && gsec) ltag = "R4 locked";
        else ltag = "R6 locked";
        chk(bank_o === 2'(s_bank[idx]), "R1 bank", bank_o, s_bank[idx]);
        chk(sector_o === 8'(idx), "R2 sector", sector_o, idx);
        chk(boot_o === eboot, "R3 boot", boot_o, eboot);
        chk(locked_o === elock, ltag, locked_o, elock);
        chk(allow_o === eallow, "R7 allow", allow_o, eallow);
        m_grant = eallow;
        if (eallow) m_gbank = s_bank[idx];
    endtask

    task automatic rand_bits();
        for (int k = 0; k < NS; k++) begin
            pbits[k] = ($urandom_range(0, 5) == 0);
            vbits[k] = ($urandom_range(0, 5) == 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        add_run(0, 8, 4096);  add_run(0, 15, 32768);
        add_run(1, 48, 32768); add_run(2, 48, 32768);
        add_run(3, 15, 32768); add_run(3, 8, 4096);

        repeat (3) @(negedge clk);
        chk(grant_o === 1'b0, "R8 reset grant", grant_o, 0);
        chk(grant_bank_o === 2'd0, "R8 reset bank", grant_bank_o, 0);
        rst = 1'b0;

        // R1 R2 R3 R7: every sector's first and last word, nothing locked
        for (int k = 0; k < NS; k++) begin
            apply(22'(s_start[k]), 1'b1, 1'b1, 1'b1);
            apply(22'(s_start[k] + s_size[k] - 1), 1'b1, 1'b1, 1'b1);
        end

        // R6: random per-sector lock bits at every boundary
        rand_bits();
        for (int k = 0; k < NS; k++) begin
            apply(22'(s_start[k]), 1'b1, 1'b1, 1'b1);
            apply(22'(s_start[k] + s_size[k] - 1), k[0], 1'b1, 1'b1);
        end

        // R4: guard pin low over all boot sectors, bits clear
        pbits = '0; vbits = '0;
        for (int k = 0; k < NS; k++) begin
            if (s_size[k] == 4096) begin
                apply(22'(s_start[k]), 1'b1, 1'b0, 1'b1);
                apply(22'(s_start[k] + 4095), 1'b1, 1'b0, 1'b1);
            end
        end

        // R5: lock-all pin low at random addresses
        for (int k = 0; k < 40; k++)
            apply(22'($urandom), 1'b1, 1'($urandom), 1'b0);

        // R8 reset clears a held bank
        apply(22'h3FFFFF, 1'b1, 1'b1, 1'b1);
        apply(22'h3FFFFF, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        chk(grant_bank_o === 2'd3, "R8 held bank", grant_bank_o, 3);
        rst = 1'b1; req = 1'b0;
        @(negedge clk);
        chk(grant_o === 1'b0, "R8 mid reset grant", grant_o, 0);
        chk(grant_bank_o === 2'd0, "R8 mid reset bank", grant_bank_o, 0);
        rst = 1'b0;
        m_grant = 1'b0; m_gbank = 0;

        // R7 R8: random mix of all inputs
        rand_bits();
        for (int k = 0; k < 400; k++)
            apply(22'($urandom), 1'($urandom), ($urandom_range(0, 3) != 0),
                  ($urandom_range(0, 7) != 0));
        apply(22'h000000, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        chk(grant_o === m_grant, "R8 final grant", grant_o, m_grant);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule